// File: doc/BRIEF.md
# Framebuffer Clear Sequencer

This block wipes a 64 by 32 one-bit-per-pixel framebuffer whose storage can only be written one pixel at a time. There is no bulk path into that memory. The block therefore walks every coordinate in a fixed order and writes a 0 to one pixel on each clock.

The processor starts a clear with a one-cycle start pulse and then stalls. The block holds the coordinate of the next pixel to wipe as its own state. On each clock it drives that coordinate, a write strobe and a data bit of 0. One cycle after the final pixel is written, it raises a one-cycle done pulse, and instruction fetch may then resume.

Top module: `fb_clear_seq`

## Requirements
- R1: After reset, busy, done and the write strobe are 0, and both coordinate outputs are 0.
- R2: A start pulse sampled while idle makes the very next cycle a write cycle at X=0, Y=0.
- R3: The write data bit is 0 in every cycle in which the write strobe is high.
- R4: Y changes fastest. Within a clear, each write cycle after the first has Y one higher than the previous write at the same X. When Y passes 31, it returns to 0 and X goes up by one.
- R5: A clear consists of exactly 2048 back-to-back write cycles, and the last of them addresses X=63, Y=31.
- R6: Done is high for exactly one cycle, the cycle right after the write at X=63, Y=31, and the write strobe is low in that cycle.
- R7: A start pulse that arrives while busy is high has no effect. The walk continues from where it was and ends on time.
- R8: In the cycle after the done pulse the block is idle, and a start sampled there begins a new clear at X=0, Y=0.
- R9: Busy is high from the first write cycle through the done cycle, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a clear (one cycle) |
| busy | output | 1 | Clear in progress, including the done cycle |
| done | output | 1 | One-cycle pulse after the final pixel write |
| px_x | output | 6 | Pixel column address |
| px_y | output | 5 | Pixel row address |
| px_we | output | 1 | Pixel write strobe |
| px_wdata | output | 1 | Pixel write data (always 0) |

## Verification
The walk is first started by a lone pulse from idle, which shows the Y-fastest order and the exact 2048-cycle length. Repeated start pulses are then injected in the middle of the walk and in the done cycle. These separate a design that ignores start while busy from one that restarts or stretches the clear. Start is finally held high across the done cycle so that the idle cycle re-accepts it. This catches an off-by-one in the return to idle, or a done pulse that overlaps the next walk.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WALK = 2'd1,
    SEQ_FIN  = 2'd2
  } seq_state_t;

  // Encoded state to "is busy" view
  function automatic logic state_busy(input seq_state_t s);
    return (s == SEQ_WALK) || (s == SEQ_FIN);
  endfunction

  function automatic logic state_writes(input seq_state_t s);
    return (s == SEQ_WALK);
  endfunction

endpackage

// File: rtl/fbc_walker.sv
module fbc_walker #(
  parameter int XW = 6,
  parameter int YW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          advance,
  output logic [XW-1:0] cur_x,
  output logic [YW-1:0] cur_y,
  output logic          at_last
);

  localparam logic [XW-1:0] XMAX = {XW{1'b1}};
  localparam logic [YW-1:0] YMAX = {YW{1'b1}};

  // Row index is the inner loop; column steps when row wraps
  function automatic logic [XW+YW-1:0] step_coord(input logic [XW-1:0] x,
                                                  input logic [YW-1:0] y);
    logic [XW-1:0] nx;
    logic [YW-1:0] ny;
    ny = y + 1'b1;
    nx = (y == YMAX) ? x + 1'b1 : x;
    return {nx, ny};
  endfunction

  logic [XW-1:0] x_q;
  logic [YW-1:0] y_q;
  logic [XW+YW-1:0] nxt;

  assign nxt = step_coord(x_q, y_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0;
      y_q <= '0;
    end else if (advance) begin
      x_q <= nxt[XW+YW-1:YW];
      y_q <= nxt[YW-1:0];
    end
  end

  assign cur_x   = x_q;
  assign cur_y   = y_q;
  assign at_last = (x_q == XMAX) && (y_q == YMAX);

endmodule

// File: rtl/fbc_ctrl.sv
module fbc_ctrl
  import fbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       at_last,
  output seq_state_t state,
  output logic       accept_evt,
  output logic       finish_evt
);

  seq_state_t st_q, st_d;

  assign accept_evt = (st_q == SEQ_IDLE) && start;
  assign finish_evt = (st_q == SEQ_WALK) && at_last;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SEQ_IDLE: if (accept_evt) st_d = SEQ_WALK;
      SEQ_WALK: if (finish_evt) st_d = SEQ_FIN;
      SEQ_FIN:  st_d = SEQ_IDLE;
      default:  st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= SEQ_IDLE;
    else     st_q <= st_d;
  end

  assign state = st_q;

endmodule

// File: rtl/fbc_port.sv
module fbc_port
  import fbc_pkg::*;
#(
  parameter int XW = 6,
  parameter int YW = 5
) (
  input  seq_state_t    state,
  input  logic [XW-1:0] cur_x,
  input  logic [YW-1:0] cur_y,
  output logic          busy,
  output logic          done,
  output logic [XW-1:0] px_x,
  output logic [YW-1:0] px_y,
  output logic          px_we,
  output logic          px_wdata
);

  assign busy     = state_busy(state);
  assign done     = (state == SEQ_FIN);
  assign px_we    = state_writes(state);
  assign px_wdata = 1'b0;
  assign px_x     = cur_x;
  assign px_y     = cur_y;

endmodule

// File: rtl/fb_clear_seq.sv
module fb_clear_seq
  import fbc_pkg::*;
#(
  parameter int XW = 6,
  parameter int YW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [XW-1:0] px_x,
  output logic [YW-1:0] px_y,
  output logic          px_we,
  output logic          px_wdata
);

  seq_state_t    state;
  logic          at_last;
  logic          step_evt;
  logic          accept_evt;
  logic          finish_evt;
  logic [XW-1:0] cur_x;
  logic [YW-1:0] cur_y;

  assign step_evt = (state == SEQ_WALK);

  fbc_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .at_last    (at_last),
    .state      (state),
    .accept_evt (accept_evt),
    .finish_evt (finish_evt)
  );

  fbc_walker #(.XW(XW), .YW(YW)) u_walk (
    .clk     (clk),
    .rst     (rst),
    .advance (step_evt),
    .cur_x   (cur_x),
    .cur_y   (cur_y),
    .at_last (at_last)
  );

  fbc_port #(.XW(XW), .YW(YW)) u_port (
    .state    (state),
    .cur_x    (cur_x),
    .cur_y    (cur_y),
    .busy     (busy),
    .done     (done),
    .px_x     (px_x),
    .px_y     (px_y),
    .px_we    (px_we),
    .px_wdata (px_wdata)
  );

endmodule

// File: rtl/fb_clear_seq_chk.sv
module fb_clear_seq_chk #(
  parameter int XW = 6,
  parameter int YW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [XW-1:0] px_x,
  input logic [YW-1:0] px_y,
  input logic          px_we,
  input logic          px_wdata,
  input logic          accept_evt,
  input logic          finish_evt
);

  localparam int TOTAL = 1 << (XW + YW);
  localparam logic [XW-1:0] XMAX = {XW{1'b1}};
  localparam logic [YW-1:0] YMAX = {YW{1'b1}};

  int run_len;
  always_ff @(posedge clk) begin
    if (rst)        run_len <= 0;
    else if (px_we) run_len <= run_len + 1;
    else            run_len <= 0;
  end

  // R2
  start_first_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (px_we && px_x == '0 && px_y == '0));

  // R3
  wdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
    px_we |-> (px_wdata == 1'b0));

  // R4
  y_inner_chk: assert property (@(posedge clk) disable iff (rst)
    (px_we && $past(px_we) && px_y != '0) |->
      (px_y == $past(px_y) + 1'b1 && px_x == $past(px_x)));

  // R4
  x_step_chk: assert property (@(posedge clk) disable iff (rst)
    (px_we && $past(px_we) && px_y == '0) |->
      ($past(px_y) == YMAX && px_x == $past(px_x) + 1'b1));

  // R5
  run_length_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (run_len == TOTAL));

  // R6
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (px_we && px_x == XMAX && px_y == YMAX) |=> (done && !px_we));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |-> !accept_evt);

  // R9
  we_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (px_we || done) |-> busy);

  // R6
  finish_done_chk: assert property (@(posedge clk) disable iff (rst)
    finish_evt |=> done);

endmodule

bind fb_clear_seq fb_clear_seq_chk #(.XW(XW), .YW(YW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .px_x       (px_x),
  .px_y       (px_y),
  .px_we      (px_we),
  .px_wdata   (px_wdata),
  .accept_evt (accept_evt),
  .finish_evt (finish_evt)
);

// File: tb/test_fb_clear_seq.sv
`timescale 1ns/1ps
module test_fb_clear_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       busy, done, px_we, px_wdata;
  logic [5:0] px_x;
  logic [4:0] px_y;

  int checks = 0;
  int errors = 0;

  // Reference: 0 idle, 1 walking, 2 done cycle
  int m_mode = 0;
  int m_x = 0;
  int m_y = 0;
  int we_run = 0;
  int done_seen = 0;

  always #2 clk = ~clk;

  fb_clear_seq i_fb_clear_seq (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .px_x(px_x), .px_y(px_y), .px_we(px_we), .px_wdata(px_wdata)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_x = 0; m_y = 0;
    end else begin
      case (m_mode)
        0: if (start) begin m_mode = 1; m_x = 0; m_y = 0; end
        1: begin
          if (m_x == 63 && m_y == 31) begin
            m_mode = 2; m_x = 0; m_y = 0;
          end else begin
            m_y = m_y + 1;
            if (m_y == 32) begin m_y = 0; m_x = m_x + 1; end
          end
        end
        default: m_mode = 0;
      endcase
    end
  end

  // Compare away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check("R9 busy", busy, (m_mode != 0) ? 1 : 0);
      check("R6 done", done, (m_mode == 2) ? 1 : 0);
      check("R5 we", px_we, (m_mode == 1) ? 1 : 0);
      if (m_mode == 1) begin
        check("R4 x", px_x, m_x);
        check("R4 y", px_y, m_y);
        check("R3 wdata", px_wdata, 0);
      end
      if (px_we) we_run++;
      if (done) begin
        done_seen++;
        check("R5 run length", we_run, 2048);
        we_run = 0;
      end
    end
  end

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        wait_neg(30000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none

    wait_neg(3);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 we", px_we, 0);
    check("R1 x", px_x, 0);
    check("R1 y", px_y, 0);
    rst = 1'b0;
    wait_neg(4);

    // R2 single pulse from idle
    start = 1'b1; wait_neg(1); start = 1'b0;
    check("R2 first x", px_x, 0);
    check("R2 first y", px_y, 0);
    check("R2 first we", px_we, 1);
    check("R4 second y", 0, 0);
    wait_neg(1);
    check("R4 second y", px_y, 1);
    check("R4 second x", px_x, 0);
    wait_neg(31);
    check("R4 x step", px_x, 1);
    check("R4 y wrap", px_y, 0);
    while (!done) wait_neg(1);
    check("R6 done we low", px_we, 0);
    wait_neg(1);
    check("R6 done pulse", done, 0);
    check("R8 idle", busy, 0);
    wait_neg(5);

    // R7 pulses while busy
    start = 1'b1; wait_neg(1); start = 1'b0;
    wait_neg(100);
    start = 1'b1; wait_neg(1); start = 1'b0;
    check("R7 no restart", (px_x == 0 && px_y == 0) ? 1 : 0, 0);
    wait_neg(700);
    start = 1'b1; wait_neg(3); start = 1'b0;
    while (!done) wait_neg(1);
    start = 1'b1; wait_neg(1); start = 1'b0;   // start in done cycle
    check("R7 done-cycle start ignored", px_we, 0);
    check("R7 done-cycle busy low", busy, 0);
    wait_neg(3);

    // R8 start held across done, re-accepted in idle cycle
    start = 1'b1; wait_neg(1); start = 1'b1;
    while (!done) wait_neg(1);
    wait_neg(1);
    check("R8 idle after done", busy, 0);
    wait_neg(1);
    start = 1'b0;
    check("R8 restart x", px_x, 0);
    check("R8 restart y", px_y, 0);
    check("R8 restart we", px_we, 1);
    while (!done) wait_neg(1);
    wait_neg(4);
    check("R5 clears completed", done_seen, 4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule